// File: doc/BRIEF.md
# Two-Wire Control Register Slave with Pointer Auto-Increment

This block is a slave on a two-wire serial bus (I2C-style). It holds a bank of 8-bit control registers that drive the rest of a receiver chip, plus a few read-only status registers whose contents come from inputs. The bus clock and data lines are sampled by the fast system clock. The block pulls the data line low through an open-drain enable and never drives it high.

A master first writes a register address byte, which loads an internal pointer. Every data byte it then writes lands at the pointer, and the pointer steps forward after each byte. To read, the master sends the register address in write direction, issues a repeated START, re-addresses the device in read direction and clocks bytes out, one register per byte. Two side effects matter to the chip. A write to register 2 (the low divider byte) sends a one-cycle start pulse to the oscillator search logic. A power-down bit is passed through to the analog side, while the bus logic and all stored values keep working.

Top module: `tuner_ctl_i2c`

## Requirements
- R1: After reset, `sda_oe` is 0, all control registers are 0x00, and `search_start` and `power_down` are 0.
- R2: The slave pulls SDA low in the 9th clock only after the address byte 0xC0 (write) or 0xC1 (read), i.e. device address 7'b1100000 in bits 7:1 and R/W in bit 0. It does not acknowledge any other address, and a transaction sent to another address changes no register.
- R3: In a write transaction, the byte after the device address loads the register pointer. Each following byte is acknowledged and stored at the pointer, and the pointer then advances by one. This continues until STOP.
- R4: After a repeated START with the read address 0xC1, the slave sends the register at the pointer MSB first, one bit per SCL cycle. After each byte the pointer advances, and a master ACK (SDA low in the 9th clock) makes the slave send the next register.
- R5: After a master NACK (SDA high in the 9th clock), the slave keeps SDA released for any further SCL clocks until the master issues START or STOP.
- R6: Storing a byte at register 2 produces exactly one `search_start` pulse, one clock wide. Writes to any other register produce none.
- R7: Registers 12 and 13 are read-only and return `status_in[7:0]` and `status_in[15:8]`. Writes to them are acknowledged and discarded.
- R8: The pointer wraps from 13 to 0. A register address byte of 14 or above sets the pointer to 0.
- R9: `power_down` follows bit 0 of register 9. While it is set, bus writes and reads still work, and all register values are unchanged when it is cleared again.
- R10: The slave changes `sda_oe` only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 = pull the data line low |
| status_in | input | 16 | Values returned for read-only registers 12 and 13 |
| ctrl_regs | output | 96 | Control registers 0..11, register n at bits 8n+7:8n |
| search_start | output | 1 | One-cycle pulse after a write to register 2 |
| power_down | output | 1 | Power-down request to the analog side |

## Verification
The bench checks the wrap of the pointer past the last status register. A design that got it wrong would either corrupt register 0 or hand back stale data where register 0 was expected. It checks that a byte written to a read-only register is still acknowledged and then dropped. A slave that got this wrong would hang the master with a NACK or let the byte overwrite a control register. After a master NACK it toggles SCL for extra clocks, which catches a slave that keeps driving data onto a bus it no longer owns. It also counts `search_start` pulses across writes that do and do not touch register 2, so a strobe that fires on the wrong register or stays high too long shows up.

// File: rtl/tuner_i2c_pkg.sv
package tuner_i2c_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_ACK_ADDR,
    S_REG,
    S_ACK_W,
    S_WDATA,
    S_RDATA,
    S_RACK,
    S_IGNORE
  } slv_state_t;
endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic              scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_lvl   = scl_pipe[STAGES-1];
  assign sda_lvl   = sda_pipe[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_d;
  assign scl_fall  = ~scl_lvl & scl_d;
  // data edges only count as framing while the clock stays high
  assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/i2c_slv_fsm.sv
module i2c_slv_fsm
  import tuner_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1100000,
  parameter int         N_REGS   = 14,
  localparam int        PTR_W    = $clog2(N_REGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_lvl,
  input  logic             sda_lvl,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rd_data,
  output logic [PTR_W-1:0] rd_addr,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic [7:0]       wr_data,
  output logic             sda_oe
);
  localparam logic [3:0]       BYTE_BITS = 4'(BYTE_W);
  localparam logic [7:0]       NREG8     = 8'(N_REGS);
  localparam logic [PTR_W-1:0] LAST_PTR  = PTR_W'(N_REGS - 1);

  slv_state_t       st, st_n;
  logic [3:0]       cnt, cnt_n;
  logic [7:0]       rx, rx_n, tx, tx_n, wd, wd_n;
  logic             rw, rw_n, mack, mack_n, oe, oe_n, we, we_n;
  logic [PTR_W-1:0] ptr, ptr_n, wa, wa_n;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    st_n = st;  cnt_n = cnt;  rx_n = rx;  tx_n = tx;  rw_n = rw;
    mack_n = mack;  ptr_n = ptr;  oe_n = oe;  we_n = 1'b0;
    wa_n = wa;  wd_n = wd;
    if (start_det) begin
      st_n  = S_ADDR;
      cnt_n = '0;
      oe_n  = 1'b0;
    end else if (stop_det) begin
      st_n = S_IDLE;
      oe_n = 1'b0;
    end else begin
      case (st)
        S_ADDR, S_REG, S_WDATA: begin
          if (scl_rise && cnt != BYTE_BITS) begin
            rx_n  = {rx[6:0], sda_lvl};
            cnt_n = cnt + 4'd1;
          end else if (scl_fall && cnt == BYTE_BITS) begin
            cnt_n = '0;
            if (st == S_ADDR) begin
              if (rx[7:1] == DEV_ADDR) begin
                rw_n = rx[0];
                oe_n = 1'b1;
                st_n = S_ACK_ADDR;
              end else begin
                st_n = S_IGNORE;
              end
            end else if (st == S_REG) begin
              ptr_n = (rx < NREG8) ? rx[PTR_W-1:0] : '0;
              oe_n  = 1'b1;
              st_n  = S_ACK_W;
            end else begin
              we_n  = 1'b1;
              wa_n  = ptr;
              wd_n  = rx;
              ptr_n = ptr_inc(ptr);
              oe_n  = 1'b1;
              st_n  = S_ACK_W;
            end
          end
        end
        S_ACK_ADDR: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (rw) begin
              st_n = S_RDATA;
              tx_n = rd_data;
              oe_n = ~rd_data[7];
            end else begin
              st_n = S_REG;
              oe_n = 1'b0;
            end
          end
        end
        S_ACK_W: begin
          if (scl_fall) begin
            st_n  = S_WDATA;
            cnt_n = '0;
            oe_n  = 1'b0;
          end
        end
        S_RDATA: begin
          if (scl_rise) begin
            cnt_n = cnt + 4'd1;
          end else if (scl_fall) begin
            if (cnt == BYTE_BITS) begin
              st_n  = S_RACK;
              oe_n  = 1'b0;
              ptr_n = ptr_inc(ptr);
            end else begin
              tx_n = {tx[6:0], 1'b0};
              oe_n = ~tx[6];
            end
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            mack_n = ~sda_lvl;
          end else if (scl_fall) begin
            cnt_n = '0;
            if (mack) begin
              st_n = S_RDATA;
              tx_n = rd_data;
              oe_n = ~rd_data[7];
            end else begin
              st_n = S_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  cnt <= '0;  rx <= '0;  tx <= '0;  rw <= 1'b0;
      mack <= 1'b0;  ptr <= '0;  oe <= 1'b0;  we <= 1'b0;
      wa <= '0;  wd <= '0;
    end else begin
      st <= st_n;  cnt <= cnt_n;  rx <= rx_n;  tx <= tx_n;  rw <= rw_n;
      mack <= mack_n;  ptr <= ptr_n;  oe <= oe_n;  we <= we_n;
      wa <= wa_n;  wd <= wd_n;
    end
  end

  assign rd_addr = ptr;
  assign wr_en   = we;
  assign wr_addr = wa;
  assign wr_data = wd;
  assign sda_oe  = oe;

  // R10: the data line enable moves only in the low phase of SCL
  a_r10_sda_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !$past(scl_lvl));
  // R5: no drive while idle or after a NACK / foreign address
  a_r5_quiet_when_ignoring: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IGNORE || st == S_IDLE) |-> !sda_oe);
  // R8: the pointer never leaves the register range
  a_r8_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST_PTR);
  // R3: each received data byte yields exactly one store pulse
  a_r3_single_store: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank #(
  parameter int  N_CTRL     = 12,
  parameter int  N_STAT     = 2,
  parameter int  SEARCH_REG = 2,
  parameter int  PD_REG     = 9,
  parameter int  PD_BIT     = 0,
  localparam int N_REGS     = N_CTRL + N_STAT,
  localparam int PTR_W      = $clog2(N_REGS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [PTR_W-1:0]      wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [PTR_W-1:0]      rd_addr,
  output logic [7:0]            rd_data,
  input  logic [N_STAT*8-1:0]   status_in,
  output logic [N_CTRL*8-1:0]   ctrl_flat,
  output logic                  search_start,
  output logic                  power_down
);
  logic [7:0] ctrl_q [N_CTRL];
  logic [7:0] all_q  [N_REGS];
  logic       strobe_q;

  for (genvar g = 0; g < N_CTRL; g++) begin : g_ctrl
    logic ce;
    assign ce = wr_en && (wr_addr == PTR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ctrl_q[g] <= '0;
      else if (ce) ctrl_q[g] <= wr_data;
    end
    assign ctrl_flat[g*8 +: 8] = ctrl_q[g];
    assign all_q[g]            = ctrl_q[g];
  end

  for (genvar s = 0; s < N_STAT; s++) begin : g_stat
    assign all_q[N_CTRL+s] = status_in[s*8 +: 8];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_REGS; i++)
      if (rd_addr == PTR_W'(i)) rd_data = all_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= wr_en && (wr_addr == PTR_W'(SEARCH_REG));
  end

  assign search_start = strobe_q;
  assign power_down   = ctrl_q[PD_REG][PD_BIT];

  // R6: the search start is a single-cycle pulse
  a_r6_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    search_start |=> !search_start);
  // R7: a store aimed at a read-only slot leaves the control outputs alone
  a_r7_status_store_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= PTR_W'(N_CTRL)) |=> $stable(ctrl_flat));
endmodule

// File: rtl/tuner_ctl_i2c.sv
module tuner_ctl_i2c #(
  parameter logic [6:0] DEV_ADDR   = 7'b1100000,
  parameter int         N_CTRL     = 12,
  parameter int         N_STAT     = 2,
  parameter int         SEARCH_REG = 2,
  parameter int         PD_REG     = 9,
  parameter int         PD_BIT     = 0,
  parameter int         SYNC_STG   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe,
  input  logic [N_STAT*8-1:0] status_in,
  output logic [N_CTRL*8-1:0] ctrl_regs,
  output logic                search_start,
  output logic                power_down
);
  localparam int N_REGS = N_CTRL + N_STAT;
  localparam int PTR_W  = $clog2(N_REGS);

  logic [1:0]       rst_pipe;
  logic             rst_core_n;
  logic             scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic [PTR_W-1:0] rd_addr, wr_addr;
  logic [7:0]       rd_data, wr_data;
  logic             wr_en;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  i2c_pin_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  i2c_slv_fsm #(.DEV_ADDR(DEV_ADDR), .N_REGS(N_REGS)) u_fsm (
    .clk(clk), .rst_n(rst_core_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sda_oe(sda_oe)
  );

  ctl_reg_bank #(
    .N_CTRL(N_CTRL), .N_STAT(N_STAT), .SEARCH_REG(SEARCH_REG),
    .PD_REG(PD_REG), .PD_BIT(PD_BIT)
  ) u_bank (
    .clk(clk), .rst_n(rst_core_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .status_in(status_in), .ctrl_flat(ctrl_regs),
    .search_start(search_start), .power_down(power_down)
  );
endmodule

// File: tb/tuner_ctl_i2c_bench.sv
module tuner_ctl_i2c_bench;
  localparam int Q = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        m_low = 1'b0;
  logic        sda_bus;
  logic        sda_oe;
  logic [15:0] status_in = 16'h3C96;
  logic [95:0] ctrl_regs;
  logic        search_start, power_down;

  int nchk = 0, nfail = 0, cycles = 0;
  int strobe_cnt = 0, run_len = 0, run_max = 0;
  bit mon_en = 0, oe_seen = 0, done = 0;
  logic [7:0] exp_ctrl [12];
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];

  always #2.5 clk = ~clk;
  assign sda_bus = ~(m_low | sda_oe);

  tuner_ctl_i2c u_tuner_ctl_i2c (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .status_in(status_in), .ctrl_regs(ctrl_regs),
    .search_start(search_start), .power_down(power_down)
  );

  always @(negedge clk) begin
    cycles++;
    if (search_start) begin
      if (run_len == 0) strobe_cnt++;
      run_len++;
      if (run_len > run_max) run_max = run_len;
    end else run_len = 0;
    if (mon_en && sda_oe) oe_seen = 1;
    if (cycles >= 150000 && !done) begin
      done = 1;
      nfail++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    m_low = 0; wq(Q); scl = 1; wq(Q); m_low = 1; wq(Q); scl = 0; wq(Q);
  endtask

  task automatic bstop();
    scl = 0; m_low = 1; wq(Q); scl = 1; wq(Q); m_low = 0; wq(Q);
  endtask

  task automatic sbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; wq(Q); scl = 1; wq(Q); scl = 0; wq(Q);
    end
    m_low = 0; wq(Q); scl = 1; wq(Q/2); ack = ~sda_bus; wq(Q/2); scl = 0; wq(Q);
  endtask

  task automatic rbyte(output logic [7:0] b, input bit mack);
    b = '0;
    m_low = 0;
    for (int i = 0; i < 8; i++) begin
      wq(Q); scl = 1; wq(Q/2); b = {b[6:0], sda_bus}; wq(Q/2); scl = 0;
    end
    wq(Q/2); m_low = mack; wq(Q); scl = 1; wq(Q); scl = 0; wq(Q/2); m_low = 0;
  endtask

  function automatic int next_p(input int p);
    return (p == 13) ? 0 : p + 1;
  endfunction

  function automatic logic [7:0] exp_rd(input int p);
    if (p < 12) return exp_ctrl[p];
    return (p == 12) ? status_in[7:0] : status_in[15:8];
  endfunction

  task automatic bus_write(input logic [7:0] ra, input int n, output int nacks);
    bit a;
    int p;
    nacks = 0;
    bstart();
    sbyte(8'hC0, a); if (!a) nacks++;
    sbyte(ra, a);    if (!a) nacks++;
    p = (ra < 14) ? int'(ra) : 0;
    for (int i = 0; i < n; i++) begin
      sbyte(wbuf[i], a); if (!a) nacks++;
      if (p < 12) exp_ctrl[p] = wbuf[i];
      p = next_p(p);
    end
    bstop();
  endtask

  task automatic bus_read(input logic [7:0] ra, input int n, output int nacks);
    bit a;
    nacks = 0;
    bstart();
    sbyte(8'hC0, a); if (!a) nacks++;
    sbyte(ra, a);    if (!a) nacks++;
    bstart();
    sbyte(8'hC1, a); if (!a) nacks++;
    for (int i = 0; i < n; i++) rbyte(rbuf[i], (i < n - 1));
    bstop();
  endtask

  task automatic cmp_ctrl(input string req);
    for (int i = 0; i < 12; i++)
      chk(req, $sformatf("ctrl reg %0d", i), 32'(ctrl_regs[i*8 +: 8]), 32'(exp_ctrl[i]));
  endtask

  task automatic t_reset();
    chk("R1", "sda_oe after reset", 32'(sda_oe), 0);
    chk("R1", "ctrl_regs zero", 32'(ctrl_regs == '0), 1);
    chk("R1", "search_start", 32'(search_start), 0);
    chk("R1", "power_down", 32'(power_down), 0);
  endtask

  task automatic t_foreign_addr();
    bit a;
    bstart();
    sbyte(8'hE0, a);
    chk("R2", "ack for foreign address", 32'(a), 0);
    sbyte(8'h00, a); sbyte(8'h77, a);
    bstop();
    chk("R2", "regs untouched by foreign address", 32'(ctrl_regs == '0), 1);
  endtask

  task automatic t_write_burst();
    int nk;
    wbuf[0] = 8'h0E; wbuf[1] = 8'hD8; wbuf[2] = 8'hE1;
    bus_write(8'h00, 3, nk);
    chk("R3", "missing acks in burst write", nk, 0);
    cmp_ctrl("R3");
    chk("R6", "strobe count after reg 2 write", strobe_cnt, 1);
    chk("R6", "strobe width", run_max, 1);
  endtask

  task automatic t_strobe_select();
    int nk;
    wbuf[0] = 8'h33; wbuf[1] = 8'h44;
    bus_write(8'h03, 2, nk);
    chk("R6", "no strobe for regs 3,4", strobe_cnt, 1);
    wbuf[0] = 8'h5C;
    bus_write(8'h02, 1, nk);
    chk("R6", "strobe count after second reg 2 write", strobe_cnt, 2);
    chk("R6", "strobe width after second write", run_max, 1);
    cmp_ctrl("R3");
  endtask

  task automatic t_read_combined();
    int nk;
    bus_read(8'h00, 4, nk);
    chk("R4", "missing acks in read", nk, 0);
    for (int i = 0; i < 4; i++)
      chk("R4", $sformatf("read byte %0d", i), 32'(rbuf[i]), 32'(exp_rd(i)));
  endtask

  task automatic t_nack_release();
    bit a;
    logic [7:0] b;
    int nk;
    bstart();
    sbyte(8'hC0, a); sbyte(8'h01, a);
    bstart();
    sbyte(8'hC1, a);
    rbyte(b, 1'b0);
    chk("R5", "byte before NACK", 32'(b), 32'(exp_rd(1)));
    mon_en = 1;
    for (int i = 0; i < 9; i++) begin
      wq(Q); scl = 1; wq(Q); scl = 0;
    end
    wq(Q);
    mon_en = 0;
    chk("R5", "slave drove SDA after NACK", 32'(oe_seen), 0);
    bstop();
    bus_read(8'h04, 1, nk);
    chk("R5", "read after NACK+STOP", 32'(rbuf[0]), 32'(exp_rd(4)));
  endtask

  task automatic t_status();
    int nk;
    wbuf[0] = 8'hFF; wbuf[1] = 8'hEE;
    bus_write(8'h0C, 2, nk);
    chk("R7", "acks for read-only write", nk, 0);
    bus_read(8'h0C, 2, nk);
    chk("R7", "reg 12 reads status low", 32'(rbuf[0]), 32'h96);
    chk("R7", "reg 13 reads status high", 32'(rbuf[1]), 32'h3C);
    cmp_ctrl("R7");
  endtask

  task automatic t_wrap();
    int nk;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    bus_write(8'h0B, 4, nk);
    chk("R8", "acks across wrap", nk, 0);
    chk("R8", "reg 0 after wrap", 32'(ctrl_regs[7:0]), 32'h44);
    cmp_ctrl("R8");
    bus_read(8'h0D, 2, nk);
    chk("R8", "read reg 13", 32'(rbuf[0]), 32'h3C);
    chk("R8", "read wraps to reg 0", 32'(rbuf[1]), 32'h44);
    bus_read(8'h20, 1, nk);
    chk("R8", "out of range pointer reads reg 0", 32'(rbuf[0]), 32'h44);
  endtask

  task automatic t_power_down();
    int nk;
    wbuf[0] = 8'h01;
    bus_write(8'h09, 1, nk);
    chk("R9", "power_down set", 32'(power_down), 1);
    wbuf[0] = 8'hA5;
    bus_write(8'h04, 1, nk);
    chk("R9", "acks while powered down", nk, 0);
    bus_read(8'h04, 1, nk);
    chk("R9", "readback while powered down", 32'(rbuf[0]), 32'hA5);
    wbuf[0] = 8'h00;
    bus_write(8'h09, 1, nk);
    chk("R9", "power_down cleared", 32'(power_down), 0);
    cmp_ctrl("R9");
  endtask

  initial begin
    for (int i = 0; i < 12; i++) exp_ctrl[i] = 8'h00;
    wq(5);
    rst_n = 1'b1;
    wq(5);
    t_reset();
    t_foreign_addr();
    t_write_burst();
    t_strobe_select();
    t_read_combined();
    t_nack_release();
    t_status();
    t_wrap();
    t_power_down();
    chk("R6", "total strobes", strobe_cnt, 2);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule